// File: doc/BRIEF.md
# Weighted Fair Queuing Scheduler

This block orders packet transmissions from a handful of flow queues so that each flow receives link bandwidth in proportion to its weight. It holds only packet descriptors (flow number and length). When a descriptor arrives it is stamped with a virtual finish tag. The stamp is the later of two values, the previous stamp of the same flow and the scheduler's virtual clock, plus the packet length scaled by the flow's inverse weight. The descriptor offered to the link is always the queue head with the smallest stamp. Once stamped, a descriptor keeps its tag.

The virtual clock is self-clocked. Each time the link accepts a descriptor, the clock jumps to that descriptor's tag. When every queue runs dry, the clock and all per-flow stamps return to zero. The inverse weights arrive as configuration inputs (one small multiplier per flow), so no divider is needed. A flow whose weight is large gets a small multiplier, which gives it a larger share. An arrival that finds its flow's queue full is discarded and reported with a one-cycle pulse on that flow's drop line.

A packet is "started" at the handshake cycle, where `txValid` and `linkReady` are both high. After that it cannot be recalled. The scheduler chooses the next descriptor only at these boundaries.

Top module: `wfq_scheduler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `txValid` is low and every `dropPulse` bit is low.
- R2: An accepted arrival for flow f with length L receives tag = max(lastTag[f], vClock) + L * recip[f], computed modulo 2^TAG_W. recip[f] is bits [f*RECIP_W +: RECIP_W] of `weightRecip`, and lastTag[f] is the tag of f's previous accepted arrival.
- R3: While any queue holds a descriptor, the offered descriptor is the queue head with the smallest tag (unsigned compare). On equal tags the lowest flow number wins.
- R4: Descriptors of one flow leave in their arrival order.
- R5: On a handshake the virtual clock becomes the tag of the accepted descriptor.
- R6: `txValid` is high exactly when at least one queue holds a descriptor. An arrival in one cycle makes `txValid` high in the next cycle.
- R7: While `txValid` is high and `linkReady` is low, and no arrival occurs, the offer (`txValid`, `txFlow`, `txLen`) stays unchanged in the next cycle.
- R8: An arrival to a flow that holds DEPTH descriptors before the clock edge is discarded, even when the same flow is accepted by the link in that cycle. Bit f of `dropPulse` is high for exactly the following cycle. Queued descriptors are not affected.
- R9: When no descriptor remains after a clock edge, the virtual clock and all per-flow last tags are zero.
- R10: An arrival in the same cycle as a handshake is stamped with the virtual clock value from before that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| arrValid | input | 1 | Arrival descriptor present this cycle |
| arrFlow | input | FID_W | Flow number of the arrival (below NUM_FLOWS) |
| arrLen | input | LEN_W | Packet length of the arrival |
| weightRecip | input | NUM_FLOWS*RECIP_W | Per-flow inverse-weight multipliers |
| linkReady | input | 1 | Link can take a descriptor this cycle |
| txValid | output | 1 | A descriptor is offered |
| txFlow | output | FID_W | Flow of the offered descriptor |
| txLen | output | LEN_W | Length of the offered descriptor |
| dropPulse | output | NUM_FLOWS | One-cycle drop indication per flow |

## Verification
A wrong tag or a stale virtual clock does not show as a bad value. It shows as a reordering at `txFlow`, one or more handshakes later, when the affected descriptor is overtaken or overtakes another. For this reason the bench compares every offered descriptor against an arithmetic model on every cycle. A selection or tie-break error shows in the same cycle that the queue heads change. A missed clear of the virtual clock after the queues drain stays hidden until tags wrap. A directed case drives tags close to the wrap point so that this error turns into a visible order swap on the next burst.

// File: rtl/wfq_pkg.sv
package wfq_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic push;   // store the arrival in its flow queue
    logic pop;    // remove the offered head
    logic clear;  // all queues empty after this edge
  } wfqStrobes_t;
endpackage

// File: rtl/wfq_flow_queue.sv
module wfq_flow_queue #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 24,
  parameter int LEN_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [TAG_W-1:0] pushTag,
  input  logic [LEN_W-1:0] pushLen,
  output logic [TAG_W-1:0] headTag,
  output logic [LEN_W-1:0] headLen,
  output logic [CNT_W-1:0] count
);
  localparam int ENTRY_W = TAG_W + LEN_W;

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= {pushTag, pushLen};
  end

  assign {headTag, headLen} = store[rdPtr];
endmodule

// File: rtl/wfq_datapath.sv
module wfq_datapath
  import wfq_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int DEPTH     = 4,
  parameter int TAG_W     = 24,
  parameter int LEN_W     = 8,
  parameter int RECIP_W   = 8,
  parameter int FID_W     = 2,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  wfqStrobes_t                          strobes,
  input  logic [FID_W-1:0]                     pushFlow,
  input  logic [FID_W-1:0]                     popFlow,
  input  logic [LEN_W-1:0]                     arrLen,
  input  logic [NUM_FLOWS*RECIP_W-1:0]         weightRecip,
  output logic [NUM_FLOWS-1:0][TAG_W-1:0]      headTags,
  output logic [NUM_FLOWS-1:0][LEN_W-1:0]      headLens,
  output logic [NUM_FLOWS-1:0][CNT_W-1:0]      counts
);
  logic [TAG_W-1:0]                 vClock;
  logic [NUM_FLOWS-1:0][TAG_W-1:0]  lastTag;
  logic [RECIP_W-1:0]               selRecip;
  logic [TAG_W-1:0]                 startTag, scaledLen, newTag;

  // Finish tag of the arrival, stamped against the pre-edge virtual clock
  always_comb begin
    selRecip  = weightRecip[pushFlow*RECIP_W +: RECIP_W];
    startTag  = (lastTag[pushFlow] > vClock) ? lastTag[pushFlow] : vClock;
    scaledLen = TAG_W'(arrLen) * TAG_W'(selRecip);
    newTag    = startTag + scaledLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vClock  <= '0;
      lastTag <= '0;
    end else if (strobes.clear) begin
      vClock  <= '0;
      lastTag <= '0;
    end else begin
      if (strobes.pop)  vClock <= headTags[popFlow];
      if (strobes.push) lastTag[pushFlow] <= newTag;
    end
  end

  for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_queue
    logic pushHere, popHere;
    assign pushHere = strobes.push && (pushFlow == FID_W'(f));
    assign popHere  = strobes.pop  && (popFlow  == FID_W'(f));

    wfq_flow_queue #(
      .DEPTH (DEPTH),
      .TAG_W (TAG_W),
      .LEN_W (LEN_W)
    ) u_queue (
      .clk     (clk),
      .rstN    (rstN),
      .push    (pushHere),
      .pop     (popHere),
      .pushTag (newTag),
      .pushLen (arrLen),
      .headTag (headTags[f]),
      .headLen (headLens[f]),
      .count   (counts[f])
    );
  end
endmodule

// File: rtl/wfq_control.sv
module wfq_control
  import wfq_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int DEPTH     = 4,
  parameter int TAG_W     = 24,
  parameter int FID_W     = 2,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             arrValid,
  input  logic [FID_W-1:0]                 arrFlow,
  input  logic                             linkReady,
  input  logic [NUM_FLOWS-1:0][TAG_W-1:0]  headTags,
  input  logic [NUM_FLOWS-1:0][CNT_W-1:0]  counts,
  output wfqStrobes_t                      strobes,
  output logic [FID_W-1:0]                 selFlow,
  output logic                             offerValid,
  output logic [NUM_FLOWS-1:0]             dropPulse
);
  logic             arrFull;
  logic [TAG_W-1:0] bestTag;
  logic [NUM_FLOWS-1:0] keepsData;

  // Smallest head tag; strict compare keeps the lowest flow on ties
  always_comb begin
    offerValid = 1'b0;
    selFlow    = '0;
    bestTag    = '0;
    for (int f = 0; f < NUM_FLOWS; f++) begin
      if (counts[f] != '0) begin
        if (!offerValid || (headTags[f] < bestTag)) begin
          offerValid = 1'b1;
          selFlow    = FID_W'(f);
          bestTag    = headTags[f];
        end
      end
    end
  end

  assign arrFull      = (counts[arrFlow] == CNT_W'(DEPTH));
  assign strobes.push = arrValid && !arrFull;
  assign strobes.pop  = offerValid && linkReady;

  // Occupancy after this edge, per flow
  always_comb begin
    for (int f = 0; f < NUM_FLOWS; f++) begin
      keepsData[f] =
        ((counts[f] != '0) &&
         !(strobes.pop && (selFlow == FID_W'(f)) && (counts[f] == CNT_W'(1)))) ||
        (strobes.push && (arrFlow == FID_W'(f)));
    end
  end
  assign strobes.clear = (keepsData == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dropPulse <= '0;
    end else if (arrValid && arrFull) begin
      dropPulse <= NUM_FLOWS'(1) << arrFlow;
    end else begin
      dropPulse <= '0;
    end
  end
endmodule

// File: rtl/wfq_scheduler.sv
module wfq_scheduler
  import wfq_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int DEPTH     = 4,
  parameter int TAG_W     = 24,
  parameter int LEN_W     = 8,
  parameter int RECIP_W   = 8,
  localparam int FID_W    = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         arrValid,
  input  logic [FID_W-1:0]             arrFlow,
  input  logic [LEN_W-1:0]             arrLen,
  input  logic [NUM_FLOWS*RECIP_W-1:0] weightRecip,
  input  logic                         linkReady,
  output logic                         txValid,
  output logic [FID_W-1:0]             txFlow,
  output logic [LEN_W-1:0]             txLen,
  output logic [NUM_FLOWS-1:0]         dropPulse
);
  wfqStrobes_t                     strobes;
  logic [NUM_FLOWS-1:0][TAG_W-1:0] headTags;
  logic [NUM_FLOWS-1:0][LEN_W-1:0] headLens;
  logic [NUM_FLOWS-1:0][CNT_W-1:0] counts;

  wfq_control #(
    .NUM_FLOWS (NUM_FLOWS),
    .DEPTH     (DEPTH),
    .TAG_W     (TAG_W),
    .FID_W     (FID_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .arrValid   (arrValid),
    .arrFlow    (arrFlow),
    .linkReady  (linkReady),
    .headTags   (headTags),
    .counts     (counts),
    .strobes    (strobes),
    .selFlow    (txFlow),
    .offerValid (txValid),
    .dropPulse  (dropPulse)
  );

  wfq_datapath #(
    .NUM_FLOWS (NUM_FLOWS),
    .DEPTH     (DEPTH),
    .TAG_W     (TAG_W),
    .LEN_W     (LEN_W),
    .RECIP_W   (RECIP_W),
    .FID_W     (FID_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .pushFlow    (arrFlow),
    .popFlow     (txFlow),
    .arrLen      (arrLen),
    .weightRecip (weightRecip),
    .headTags    (headTags),
    .headLens    (headLens),
    .counts      (counts)
  );

  assign txLen = headLens[txFlow];
endmodule

// File: rtl/wfq_scheduler_checker.sv
module wfq_scheduler_checker #(
  parameter int NUM_FLOWS = 4,
  parameter int FID_W     = 2,
  parameter int LEN_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 arrValid,
  input logic [FID_W-1:0]     arrFlow,
  input logic                 linkReady,
  input logic                 txValid,
  input logic [FID_W-1:0]     txFlow,
  input logic [LEN_W-1:0]     txLen,
  input logic [NUM_FLOWS-1:0] dropPulse
);
  // R1: quiet outputs while held in reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!txValid && (dropPulse == '0))
        else $error("reset outputs not quiet");
    end
  end

  // R6: an arrival leaves something to offer
  assert_arrival_offers_R6: assert property (@(posedge clk) disable iff (!rstN)
    arrValid |=> txValid);

  // R6: an offer not taken is still there next cycle
  assert_work_conserving_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !linkReady) |=> txValid);

  // R7: offer held while the link waits and nothing arrives
  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !linkReady && !arrValid) |=> ($stable(txFlow) && $stable(txLen)));

  // R8: at most one drop line at a time
  assert_drop_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dropPulse));

  // R8: a drop follows an arrival to that same flow
  assert_drop_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dropPulse != '0) |-> ($past(arrValid) && dropPulse[$past(arrFlow)]));
endmodule

bind wfq_scheduler wfq_scheduler_checker #(
  .NUM_FLOWS (NUM_FLOWS),
  .FID_W     (FID_W),
  .LEN_W     (LEN_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .arrValid  (arrValid),
  .arrFlow   (arrFlow),
  .linkReady (linkReady),
  .txValid   (txValid),
  .txFlow    (txFlow),
  .txLen     (txLen),
  .dropPulse (dropPulse)
);

// File: tb/wfq_scheduler_tb.sv
`timescale 1ns/1ps
module wfq_scheduler_tb;
  localparam int NF    = 4;
  localparam int DEPTH = 4;
  localparam int TAG_W = 12;
  localparam int LEN_W = 8;
  localparam int RW    = 4;
  localparam int MASK  = (1 << TAG_W) - 1;

  logic              clk = 1'b0;
  logic              rstN;
  logic              arrValid;
  logic [1:0]        arrFlow;
  logic [LEN_W-1:0]  arrLen;
  logic [NF*RW-1:0]  weightRecip;
  logic              linkReady;
  logic              txValid;
  logic [1:0]        txFlow;
  logic [LEN_W-1:0]  txLen;
  logic [NF-1:0]     dropPulse;

  always #2 clk = ~clk;

  wfq_scheduler #(
    .NUM_FLOWS (NF), .DEPTH (DEPTH), .TAG_W (TAG_W),
    .LEN_W (LEN_W), .RECIP_W (RW)
  ) u_dut (
    .clk (clk), .rstN (rstN), .arrValid (arrValid), .arrFlow (arrFlow),
    .arrLen (arrLen), .weightRecip (weightRecip), .linkReady (linkReady),
    .txValid (txValid), .txFlow (txFlow), .txLen (txLen), .dropPulse (dropPulse)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Arithmetic model state
  int mTag [NF][DEPTH];
  int mLen [NF][DEPTH];
  int mCnt [NF];
  int mLast[NF];
  int mVt;
  int recip[NF];
  logic [NF-1:0] expDrop;
  int recFlow[64];
  int recLen[64];
  int recN;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setRecip(input int r0, input int r1, input int r2, input int r3);
    recip[0] = r0; recip[1] = r1; recip[2] = r2; recip[3] = r3;
    for (int f = 0; f < NF; f++) weightRecip[f*RW +: RW] = RW'(recip[f]);
  endtask

  function automatic int modelSel();
    int s = -1;
    for (int f = 0; f < NF; f++)
      if (mCnt[f] > 0 && (s < 0 || mTag[f][0] < mTag[s][0])) s = f;
    return s;
  endfunction

  function automatic int modelTotal();
    int t = 0;
    for (int f = 0; f < NF; f++) t += mCnt[f];
    return t;
  endfunction

  // One cycle: check offer at the falling edge, drive, advance model
  task automatic cycle(input bit av, input int af, input int al, input bit rdy);
    int s, base, t;
    s = modelSel();
    chk("R6 offer valid", int'(txValid === 1'b1), int'(s >= 0));
    if (s >= 0) begin
      chk("R3 offered flow", int'(txFlow), s);
      chk("R4 offered length", int'(txLen), mLen[s][0]);
    end
    chk("R8 drop lines", int'(dropPulse), int'(expDrop));
    expDrop = '0;
    if (rdy && txValid === 1'b1 && recN < 64) begin
      recFlow[recN] = int'(txFlow);
      recLen[recN]  = int'(txLen);
      recN++;
    end
    arrValid  = av;
    arrFlow   = 2'(af);
    arrLen    = LEN_W'(al);
    linkReady = rdy;
    // model: selection from pre-edge state, tag against pre-edge clock (R10)
    if (av) begin
      if (mCnt[af] == DEPTH) expDrop[af] = 1'b1;
      else begin
        base = (mLast[af] > mVt) ? mLast[af] : mVt;
        t = (base + al * recip[af]) & MASK;
        mTag[af][mCnt[af]] = t;
        mLen[af][mCnt[af]] = al;
        mCnt[af]++;
        mLast[af] = t;
      end
    end
    if (rdy && s >= 0) begin
      mVt = mTag[s][0];
      for (int i = 0; i < DEPTH - 1; i++) begin
        mTag[s][i] = mTag[s][i+1];
        mLen[s][i] = mLen[s][i+1];
      end
      mCnt[s]--;
    end
    if (modelTotal() == 0) begin
      mVt = 0;
      for (int f = 0; f < NF; f++) mLast[f] = 0;
    end
    @(negedge clk);
  endtask

  task automatic drain();
    while (modelTotal() > 0) cycle(0, 0, 1, 1);
    cycle(0, 0, 1, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rstN = 1'b0; arrValid = 0; arrFlow = 0; arrLen = 0; linkReady = 0;
    expDrop = '0; mVt = 0; recN = 0;
    for (int f = 0; f < NF; f++) begin mCnt[f] = 0; mLast[f] = 0; end
    setRecip(2, 1, 1, 15);
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(txValid), 0);
    chk("R1 drop in reset", int'(dropPulse), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(txValid), 0);
    chk("R1 drop after reset", int'(dropPulse), 0);

    // R2: weight scaling decides order (f0: 20*2=40, f1: 30*1=30)
    recN = 0;
    cycle(1, 0, 20, 0); cycle(1, 1, 30, 0);
    drain();
    chk("R2 first flow", recFlow[0], 1);
    chk("R2 second flow", recFlow[1], 0);

    // R3: equal tags 20, lowest flow first
    recN = 0;
    cycle(1, 2, 20, 0); cycle(1, 1, 20, 0);
    drain();
    chk("R3 tie first", recFlow[0], 1);
    chk("R3 tie second", recFlow[1], 2);

    // R4: per-flow arrival order
    recN = 0;
    cycle(1, 3, 5, 0); cycle(1, 3, 3, 0); cycle(1, 3, 7, 0);
    drain();
    chk("R4 len0", recLen[0], 5);
    chk("R4 len1", recLen[1], 3);
    chk("R4 len2", recLen[2], 7);

    // R5: clock jumps to 10 after first accept; f1 stamped 25, between 20 and 30
    recN = 0;
    cycle(1, 0, 5, 0); cycle(1, 0, 5, 0); cycle(1, 0, 5, 0);
    cycle(0, 0, 1, 1);
    cycle(1, 1, 15, 0);
    drain();
    chk("R5 order1", recFlow[1], 0);
    chk("R5 order2", recFlow[2], 1);
    chk("R5 order3", recFlow[3], 0);

    // R10: arrival with a handshake uses clock 0, tag 25 < 40
    recN = 0;
    cycle(1, 0, 10, 0); cycle(1, 0, 10, 0);
    cycle(1, 1, 25, 1);
    drain();
    chk("R10 order1", recFlow[1], 1);
    chk("R10 order2", recFlow[2], 0);

    // R8: fifth arrival to flow 2 dropped, four kept
    recN = 0;
    for (int i = 1; i <= 5; i++) cycle(1, 2, i, 0);
    chk("R8 drop pulse", int'(dropPulse), 4);
    cycle(0, 0, 1, 0);
    chk("R8 single pulse", int'(dropPulse), 0);
    drain();
    chk("R8 kept count", recN, 4);
    chk("R8 last kept len", recLen[3], 4);

    // R9: tag 3750 drains; without clearing, 400 would wrap to 54 and lead
    recN = 0;
    cycle(1, 3, 250, 0);
    drain();
    cycle(1, 0, 200, 0); cycle(1, 1, 100, 0);
    drain();
    chk("R9 after idle first", recFlow[1], 1);
    chk("R9 after idle second", recFlow[2], 0);

    // Sweeps over two weight settings, model checked every cycle (R3 R6 R8)
    for (int cfg = 0; cfg < 2; cfg++) begin
      if (cfg == 0) setRecip(1, 1, 1, 1); else setRecip(3, 1, 7, 2);
      for (int n = 0; n < 1500; n++)
        cycle(($urandom % 3) != 0, $urandom % NF, 1 + ($urandom % 20), $urandom % 2);
      drain();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule